// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Tracker

This block follows the control flow of one warp of SIMD threads that share a single program counter. It keeps the warp's current PC and the mask of threads that are live on that PC. When a branch sends some live threads one way and the rest the other way, the block records where the paths join again on a small LIFO stack. It then runs the taken path first and keeps the fall-through path for later.

Each stack slot holds three fields: a reconvergence PC, a thread mask and a resume PC. On a divergent branch two slots are written in the same cycle. The lower one is the join slot: the merge PC is both its reconvergence PC and its resume PC, and its mask is the whole pre-branch mask. The upper one is the deferred path: it holds the not-taken threads, the fall-through PC as resume PC and the merge PC as reconvergence PC. After every completed instruction, the PC the warp would go to next is compared with the reconvergence PC in the top slot. On a match, that slot is popped and the warp resumes from its stored PC and mask.

The surrounding pipeline does the decoding and supplies everything the block needs: the per-thread branch outcome, both targets, the merge PC and the sequential next PC. A launch pulse starts a warp.

Top module: `simtReconvStack`

## Requirements
- R1: While reset is held, and in the first cycle after it, curPc is 0, curMask is 0, overflowErr is 0 and the stack is empty.
- R2: A launch pulse loads curPc from launchPc and curMask from launchMask, empties the stack and clears overflowErr. Launch has priority over step.
- R3: A step with isBranch low moves curPc to nextPc and keeps curMask, unless the pop rule R6 applies.
- R4: For a branch step, bit i of laneTaken set means thread i takes the branch. The taken set is curMask AND laneTaken, and the fall set is curMask AND NOT laneTaken. If one of the two sets is empty, nothing is pushed. The resolved PC is takenPc when the taken set is non-empty and fallPc otherwise, and curMask is unchanged, unless R6 applies.
- R5: For a branch step where both sets are non-empty and at least two slots are free, two slots are pushed. The join slot goes in first and holds rpc=mergePc, mask=old curMask and resume=mergePc. The deferred slot goes on top of it and holds rpc=mergePc, mask=fall set and resume=fallPc. curPc becomes takenPc and curMask becomes the taken set. No pop is made in that cycle.
- R6: For a non-divergent step, if the stack is not empty and the resolved PC equals the top slot's reconvergence PC, the top slot is popped, and curPc and curMask are loaded from its resume PC and mask.
- R7: Slots are popped in reverse order of their pushes, so nested divergence unwinds from the inner level outwards.
- R8: A divergent branch with fewer than two free slots (depth DEPTH) sets overflowErr and leaves curPc, curMask and the stack unchanged. overflowErr stays set until the next launch or reset.
- R9: In a cycle with neither step nor launch, curPc, curMask and overflowErr hold.
- R10: When the stack is empty, no pop is made, and the resolved PC is always taken as the new curPc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start a warp from launchPc and launchMask |
| launchPc | input | PC_W | Start PC |
| launchMask | input | LANES | Start thread mask |
| step | input | 1 | One instruction of the warp completed |
| isBranch | input | 1 | The completed instruction is a conditional branch |
| laneTaken | input | LANES | Branch outcome per thread, 1 = taken |
| takenPc | input | PC_W | Branch target |
| fallPc | input | PC_W | Fall-through PC |
| mergePc | input | PC_W | Merge point of the branch |
| nextPc | input | PC_W | Next PC for a non-branch instruction |
| curPc | output | PC_W | PC the warp executes |
| curMask | output | LANES | Threads live at curPc |
| overflowErr | output | 1 | Sticky stack overflow flag |

## Verification
On every cycle the assertions check the following: the launch load, the plain sequential advance while the stack is empty, the exact result of a divergent branch with room (the new PC, the taken mask and the occupancy growing by two), the hold and stickiness on overflow, and the hold on idle cycles. Only the bench's scenarios can show that popped slots return the right resume PC and mask in LIFO order. The same holds for the fall-through choice on uniform branches, for a uniform branch whose target meets the merge point, and for nested unwinding. These need the model's record of what was pushed several instructions earlier.

// File: rtl/simtStackPkg.sv
package simtStackPkg;

  // Source of the next current PC and mask
  typedef enum logic [2:0] {
    SEL_HOLD     = 3'd0,
    SEL_LAUNCH   = 3'd1,
    SEL_RESOLVED = 3'd2,
    SEL_TAKEN    = 3'd3,
    SEL_POP      = 3'd4
  } pcSelE;

  // Strobes from control to datapath
  typedef struct packed {
    logic  clearStack;
    logic  pushPair;
    logic  popTop;
    logic  setOvf;
    pcSelE pcSel;
  } stackStrobeT;

endpackage

// File: rtl/simtStackCtrl.sv
module simtStackCtrl
  import simtStackPkg::*;
(
  input  logic        launch,
  input  logic        step,
  input  logic        isBranch,
  input  logic        divergent,
  input  logic        room2,
  input  logic        topMatch,
  output stackStrobeT strb
);

  always_comb begin
    strb = '{clearStack: 1'b0, pushPair: 1'b0, popTop: 1'b0,
             setOvf: 1'b0, pcSel: SEL_HOLD};
    if (launch) begin
      strb.clearStack = 1'b1;
      strb.pcSel      = SEL_LAUNCH;
    end else if (step) begin
      if (isBranch && divergent) begin
        if (room2) begin
          strb.pushPair = 1'b1;
          strb.pcSel    = SEL_TAKEN;
        end else begin
          strb.setOvf   = 1'b1;
        end
      end else if (topMatch) begin
        strb.popTop = 1'b1;
        strb.pcSel  = SEL_POP;
      end else begin
        strb.pcSel  = SEL_RESOLVED;
      end
    end
  end

endmodule

// File: rtl/simtStackData.sv
module simtStackData
  import simtStackPkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  stackStrobeT      strb,
  input  logic [PC_W-1:0]  launchPc,
  input  logic [LANES-1:0] launchMask,
  input  logic             isBranch,
  input  logic [LANES-1:0] laneTaken,
  input  logic [PC_W-1:0]  takenPc,
  input  logic [PC_W-1:0]  fallPc,
  input  logic [PC_W-1:0]  mergePc,
  input  logic [PC_W-1:0]  nextPc,
  output logic [PC_W-1:0]  curPc,
  output logic [LANES-1:0] curMask,
  output logic             overflowErr,
  output logic [CNT_W-1:0] stackCnt,
  output logic             divergent,
  output logic             room2,
  output logic             topMatch
);

  logic [PC_W-1:0]  rpcMem  [DEPTH];
  logic [PC_W-1:0]  epcMem  [DEPTH];
  logic [LANES-1:0] maskMem [DEPTH];

  logic [LANES-1:0] takenMask, fallMask;
  logic [PC_W-1:0]  resolvedPc;
  logic [PTR_W-1:0] topPtr;
  logic             stackEmpty;

  // Per-thread split of the live mask
  assign takenMask  = curMask & laneTaken;
  assign fallMask   = curMask & ~laneTaken;
  assign divergent  = (|takenMask) && (|fallMask);

  // PC the warp heads to when no divergence happens
  assign resolvedPc = !isBranch   ? nextPc :
                      |takenMask  ? takenPc : fallPc;

  assign stackEmpty = (stackCnt == '0);
  assign topPtr     = PTR_W'(stackCnt - 1'b1);
  assign room2      = ({1'b0, stackCnt} + 2) <= (CNT_W + 1)'(DEPTH);
  assign topMatch   = !stackEmpty && (resolvedPc == rpcMem[topPtr]);

  // Stack slots: the join slot is written at the current count, the
  // deferred-path slot one above it
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic wrJoin, wrOther;
    assign wrJoin = strb.pushPair && (stackCnt == CNT_W'(g));
    if (g > 0) begin : gUpper
      assign wrOther = strb.pushPair && (stackCnt == CNT_W'(g - 1));
    end else begin : gBottom
      assign wrOther = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wrJoin) begin
        rpcMem[g]  <= mergePc;
        epcMem[g]  <= mergePc;
        maskMem[g] <= curMask;
      end else if (wrOther) begin
        rpcMem[g]  <= mergePc;
        epcMem[g]  <= fallPc;
        maskMem[g] <= fallMask;
      end
    end
  end

  // Occupancy
  always_ff @(posedge clk) begin
    if (!rstN)                stackCnt <= '0;
    else if (strb.clearStack) stackCnt <= '0;
    else if (strb.pushPair)   stackCnt <= stackCnt + CNT_W'(2);
    else if (strb.popTop)     stackCnt <= stackCnt - CNT_W'(1);
  end

  // Current PC and mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPc   <= '0;
      curMask <= '0;
    end else begin
      unique case (strb.pcSel)
        SEL_LAUNCH: begin
          curPc   <= launchPc;
          curMask <= launchMask;
        end
        SEL_RESOLVED: curPc <= resolvedPc;
        SEL_TAKEN: begin
          curPc   <= takenPc;
          curMask <= takenMask;
        end
        SEL_POP: begin
          curPc   <= epcMem[topPtr];
          curMask <= maskMem[topPtr];
        end
        default: ;
      endcase
    end
  end

  // Sticky overflow flag
  always_ff @(posedge clk) begin
    if (!rstN)                overflowErr <= 1'b0;
    else if (strb.clearStack) overflowErr <= 1'b0;
    else if (strb.setOvf)     overflowErr <= 1'b1;
  end

endmodule

// File: rtl/simtReconvStack.sv
module simtReconvStack
  import simtStackPkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic [PC_W-1:0]  launchPc,
  input  logic [LANES-1:0] launchMask,
  input  logic             step,
  input  logic             isBranch,
  input  logic [LANES-1:0] laneTaken,
  input  logic [PC_W-1:0]  takenPc,
  input  logic [PC_W-1:0]  fallPc,
  input  logic [PC_W-1:0]  mergePc,
  input  logic [PC_W-1:0]  nextPc,
  output logic [PC_W-1:0]  curPc,
  output logic [LANES-1:0] curMask,
  output logic             overflowErr
);

  stackStrobeT      strb;
  logic [CNT_W-1:0] stackCnt;
  logic             divergent, room2, topMatch;

  simtStackCtrl ctrl_i (
    .launch    (launch),
    .step      (step),
    .isBranch  (isBranch),
    .divergent (divergent),
    .room2     (room2),
    .topMatch  (topMatch),
    .strb      (strb)
  );

  simtStackData #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .launchPc    (launchPc),
    .launchMask  (launchMask),
    .isBranch    (isBranch),
    .laneTaken   (laneTaken),
    .takenPc     (takenPc),
    .fallPc      (fallPc),
    .mergePc     (mergePc),
    .nextPc      (nextPc),
    .curPc       (curPc),
    .curMask     (curMask),
    .overflowErr (overflowErr),
    .stackCnt    (stackCnt),
    .divergent   (divergent),
    .room2       (room2),
    .topMatch    (topMatch)
  );

endmodule

// File: rtl/simtReconvStackChk.sv
module simtReconvStackChk #(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rstN,
  input logic             launch,
  input logic [PC_W-1:0]  launchPc,
  input logic [LANES-1:0] launchMask,
  input logic             step,
  input logic             isBranch,
  input logic [LANES-1:0] laneTaken,
  input logic [PC_W-1:0]  takenPc,
  input logic [PC_W-1:0]  nextPc,
  input logic [PC_W-1:0]  curPc,
  input logic [LANES-1:0] curMask,
  input logic             overflowErr,
  input logic [CNT_W-1:0] stackCnt
);

  logic splitNow, roomNow;
  assign splitNow = step && !launch && isBranch &&
                    ((curMask & laneTaken) != '0) && ((curMask & ~laneTaken) != '0);
  assign roomNow  = (32'(stackCnt) + 2) <= DEPTH;

  // R2: launch loads state and clears the flag
  a_r2_launch_load: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (curPc == $past(launchPc)) && (curMask == $past(launchMask)) &&
               !overflowErr && (stackCnt == '0));

  // R3 / R10: sequential advance with an empty stack
  a_r3_seq_advance: assert property (@(posedge clk) disable iff (!rstN)
    (step && !launch && !isBranch && (stackCnt == '0)) |=>
      (curPc == $past(nextPc)) && $stable(curMask));

  // R5: divergent branch with room
  a_r5_split_push: assert property (@(posedge clk) disable iff (!rstN)
    (splitNow && roomNow) |=>
      (curPc == $past(takenPc)) && (curMask == $past(curMask & laneTaken)) &&
      (32'(stackCnt) == 32'($past(stackCnt)) + 2));

  // R8: no room, state holds and the flag rises
  a_r8_overflow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (splitNow && !roomNow) |=>
      overflowErr && $stable(curPc) && $stable(curMask) && $stable(stackCnt));

  // R8: the flag is sticky until launch
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !launch) |=> overflowErr);

  // R9: idle cycles hold
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !launch) |=> $stable(curPc) && $stable(curMask) && $stable(overflowErr));

  // R7: occupancy never exceeds the depth
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(stackCnt) <= DEPTH);

endmodule

bind simtReconvStack simtReconvStackChk #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .launch      (launch),
  .launchPc    (launchPc),
  .launchMask  (launchMask),
  .step        (step),
  .isBranch    (isBranch),
  .laneTaken   (laneTaken),
  .takenPc     (takenPc),
  .nextPc      (nextPc),
  .curPc       (curPc),
  .curMask     (curMask),
  .overflowErr (overflowErr),
  .stackCnt    (stackCnt)
);

// File: tb/simtReconvStack_tb_top.sv
module simtReconvStack_tb_top;
  localparam int LANES = 4;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             launch = 1'b0;
  logic [PC_W-1:0]  launchPc = '0;
  logic [LANES-1:0] launchMask = '0;
  logic             step = 1'b0;
  logic             isBranch = 1'b0;
  logic [LANES-1:0] laneTaken = '0;
  logic [PC_W-1:0]  takenPc = '0, fallPc = '0, mergePc = '0, nextPc = '0;
  logic [PC_W-1:0]  curPc;
  logic [LANES-1:0] curMask;
  logic             overflowErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string reqTag = "R1";

  always #10 clk = ~clk;

  simtReconvStack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .launch(launch), .launchPc(launchPc),
    .launchMask(launchMask), .step(step), .isBranch(isBranch),
    .laneTaken(laneTaken), .takenPc(takenPc), .fallPc(fallPc),
    .mergePc(mergePc), .nextPc(nextPc), .curPc(curPc),
    .curMask(curMask), .overflowErr(overflowErr)
  );

  // Behavioural reference model
  int rpcQ[$];
  int epcQ[$];
  int mskQ[$];
  int expPc = 0, expMask = 0;
  bit expOvf = 1'b0;

  always @(posedge clk) begin
    int tm, fm, r;
    if (!rstN) begin
      rpcQ.delete(); epcQ.delete(); mskQ.delete();
      expPc = 0; expMask = 0; expOvf = 1'b0;
    end else if (launch) begin
      rpcQ.delete(); epcQ.delete(); mskQ.delete();
      expPc = int'(launchPc); expMask = int'(launchMask); expOvf = 1'b0;
    end else if (step) begin
      tm = expMask & int'(laneTaken);
      fm = expMask & ~int'(laneTaken) & ((1 << LANES) - 1);
      if (isBranch && tm != 0 && fm != 0) begin
        if (rpcQ.size() + 2 <= DEPTH) begin
          rpcQ.push_back(int'(mergePc)); epcQ.push_back(int'(mergePc)); mskQ.push_back(expMask);
          rpcQ.push_back(int'(mergePc)); epcQ.push_back(int'(fallPc));  mskQ.push_back(fm);
          expPc = int'(takenPc); expMask = tm;
        end else begin
          expOvf = 1'b1;
        end
      end else begin
        r = !isBranch ? int'(nextPc) : (tm != 0 ? int'(takenPc) : int'(fallPc));
        if (rpcQ.size() > 0 && rpcQ[$] == r) begin
          expPc = epcQ[$]; expMask = mskQ[$];
          void'(rpcQ.pop_back()); void'(epcQ.pop_back()); void'(mskQ.pop_back());
        end else begin
          expPc = r;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (int'(curPc) != expPc || int'(curMask) != expMask || overflowErr != expOvf) begin
        errors++;
        $display("FAIL %s: pc=%h mask=%b ovf=%b expected pc=%h mask=%b ovf=%b",
                 reqTag, curPc, curMask, overflowErr, expPc[PC_W-1:0],
                 expMask[LANES-1:0], expOvf);
      end
    end
  end

  task automatic doLaunch(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m);
    @(negedge clk);
    launch = 1'b1; launchPc = pc; launchMask = m;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic doSeq(input logic [PC_W-1:0] np);
    @(negedge clk);
    step = 1'b1; isBranch = 1'b0; nextPc = np;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic doBranch(input logic [LANES-1:0] t, input logic [PC_W-1:0] tp,
                          input logic [PC_W-1:0] fp, input logic [PC_W-1:0] mp);
    @(negedge clk);
    step = 1'b1; isBranch = 1'b1; laneTaken = t; takenPc = tp; fallPc = fp; mergePc = mp;
    @(negedge clk);
    step = 1'b0; isBranch = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    reqTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: launch
    reqTag = "R2";
    doLaunch(16'h0010, 4'b1111);

    // R3 and R9: sequential steps with idle gaps
    reqTag = "R3";
    doSeq(16'h0011);
    doSeq(16'h0012);
    reqTag = "R9";
    repeat (3) @(negedge clk);

    // R4: uniform branches, all taken, none taken, taken bits outside the mask
    reqTag = "R4";
    doBranch(4'b1111, 16'h0100, 16'h0013, 16'h0200);
    doBranch(4'b0000, 16'h0300, 16'h0101, 16'h0200);
    doLaunch(16'h0400, 4'b0011);
    doBranch(4'b1100, 16'h0500, 16'h0401, 16'h0600);

    // R5 and R6: split 1111 into 1011 (taken) and 0100, rejoin at merge
    reqTag = "R5";
    doLaunch(16'h0020, 4'b1111);
    doBranch(4'b1011, 16'h0030, 16'h0040, 16'h0050);
    doSeq(16'h0031);
    reqTag = "R6";
    doSeq(16'h0050);
    doSeq(16'h0041);
    doSeq(16'h0050);
    reqTag = "R10";
    doSeq(16'h0051);
    doSeq(16'h0050);

    // R7: nested divergence unwinds inner level first
    reqTag = "R7";
    doLaunch(16'h1000, 4'b1111);
    doBranch(4'b0011, 16'h1100, 16'h1200, 16'h1900);
    doBranch(4'b0001, 16'h1110, 16'h1120, 16'h1180);
    doSeq(16'h1180);
    doSeq(16'h1180);
    doSeq(16'h1900);
    doSeq(16'h1900);
    doSeq(16'h1901);

    // R6: uniform branch whose target meets the merge point pops
    reqTag = "R6";
    doLaunch(16'h2000, 4'b1111);
    doBranch(4'b0110, 16'h2100, 16'h2200, 16'h2300);
    doBranch(4'b1111, 16'h2300, 16'h2101, 16'h2400);
    doBranch(4'b0000, 16'h2500, 16'h2300, 16'h2400);

    // R8: overflow with depth 4, then launch clears
    reqTag = "R8";
    doLaunch(16'h3000, 4'b1111);
    doBranch(4'b0111, 16'h3100, 16'h3200, 16'h3900);
    doBranch(4'b0011, 16'h3110, 16'h3120, 16'h3800);
    doBranch(4'b0001, 16'h3111, 16'h3112, 16'h3700);
    doSeq(16'h3113);
    doSeq(16'h3800);
    reqTag = "R2";
    doLaunch(16'h4000, 4'b1010);
    doSeq(16'h4001);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule